// File: doc/BRIEF.md
# Iterative Carry-Less Multiplier

The block multiplies two 32-bit operands as polynomials over GF(2). Each partial product is merged into the running sum with XOR, so no carries pass between bit positions. A single 64-bit product is formed, and one of three 32-bit windows of it is returned: the lower half, the upper half, or the window one position below the upper half. The last of these is the "reversed" product that bit-reflected polynomial arithmetic needs.

Operands come in on a valid/ready input. The block takes a request on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole computation, so a request offered during that time is not accepted and has no effect. The requester must hold its request until `in_ready` is high. The output has no back-pressure. `res_valid` pulses for one cycle when the product is ready. `res_data` then keeps that value until the next request is accepted, so a consumer may read it at any later time. One multiplier bit is consumed per cycle.

Top module: `clmul_iter`

## Requirements
- R1: A synchronous active-high `rst` leaves `busy` and `res_valid` low, `in_ready` high and `res_data` equal to zero.
- R2: A request is accepted on an edge where `in_valid` and `in_ready` are both high. `busy` is high from the next cycle. While `busy` is high, `in_ready` is low, and any `in_valid` with its operands and mode is ignored: the running computation and its result do not change.
- R3: `res_valid` is high for exactly one cycle, W clock edges after the accepting edge (W = 32). On that same edge `busy` falls.
- R4: The 64-bit product P is the XOR, over every set bit i of `in_b`, of `in_a` shifted left by i. With all-zero operands P is zero.
- R5: Mode code 2'b00 returns P[31:0]. Code 2'b11 behaves exactly like 2'b00.
- R6: Mode code 2'b01 returns P[63:32]. Bit 0 of `in_b` has no influence on this result.
- R7: Mode code 2'b10 returns P[62:31]. This equals the 2'b01 result shifted left by one, with bit 31 of the 2'b00 result in bit 0.
- R8: From the `res_valid` cycle until the next accepted request, `res_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle, request will be taken |
| in_a | input | 32 | Multiplicand |
| in_b | input | 32 | Multiplier, one bit used per cycle |
| in_mode | input | 2 | Result window: 00 low, 01 high, 10 reversed, 11 low |
| busy | output | 1 | Computation in progress |
| res_valid | output | 1 | One-cycle pulse: result ready |
| res_data | output | 32 | Selected product window, held until next request |

## Verification
A wrong iteration count or a lost control state appears at the ports as a `res_valid` pulse on the wrong cycle, or as `in_ready` staying low. The reference model compares these on every clock, so such a fault is reported within one cycle of the expected completion. A wrong accumulator or shift-register value appears in `res_data` in the `res_valid` cycle. Driving zero, all-ones and random operands in every mode exposes it, along with any swapped or off-by-one window selection. A request that corrupts a computation already in flight shows as a mismatch at the end of that computation. A result that is not held shows as a change during the idle cycles that are checked afterwards.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  typedef enum logic [1:0] {
    CLM_LOW     = 2'b00,
    CLM_HIGH    = 2'b01,
    CLM_REV     = 2'b10,
    CLM_LOW_ALT = 2'b11
  } clm_mode_e;
endpackage

// File: rtl/clmul_seq_ctrl.sv
// Iteration sequencer: counts W steps after an accepted request.
module clmul_seq_ctrl #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  output logic busy,
  output logic done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] step_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      step_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        step_cnt <= '0;
      end else if (busy) begin
        if (step_cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step_cnt <= step_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clmul_accum.sv
// MSB-first GF(2) shift-and-XOR accumulator.
module clmul_accum #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic [2*W-1:0] acc
);
  localparam int PW = 2 * W;

  logic [W-1:0]  a_q;
  logic [W-1:0]  b_q;
  logic [W-1:0]  part;
  logic [PW-1:0] next_acc;

  for (genvar g = 0; g < W; g++) begin : g_pp
    assign part[g] = a_q[g] & b_q[W-1];
  end

  assign next_acc = {acc[PW-2:0], 1'b0} ^ {{W{1'b0}}, part};

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      acc <= '0;
    end else if (load) begin
      a_q <= opa;
      b_q <= opb;
      acc <= '0;
    end else if (step) begin
      b_q <= {b_q[W-2:0], 1'b0};
      acc <= next_acc;
    end
  end
endmodule

// File: rtl/clmul_pick.sv
// Chooses the 32-bit window of the product.
module clmul_pick
  import clmul_pkg::*;
#(
  parameter int W = 32
) (
  input  clm_mode_e      mode,
  input  logic [2*W-1:0] acc,
  output logic [W-1:0]   res
);
  always_comb begin
    unique case (mode)
      CLM_HIGH: res = acc[2*W-1:W];
      CLM_REV:  res = acc[2*W-2:W-1];
      default:  res = acc[W-1:0];
    endcase
  end
endmodule

// File: rtl/clmul_iter.sv
module clmul_iter
  import clmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [1:0]   in_mode,
  output logic         busy,
  output logic         res_valid,
  output logic [W-1:0] res_data
);
  logic           accept;
  logic [2*W-1:0] acc;
  clm_mode_e      mode_q;

  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= CLM_LOW;
    else if (accept) mode_q <= clm_mode_e'(in_mode);
  end

  clmul_seq_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .busy   (busy),
    .done   (res_valid)
  );

  clmul_accum #(.W(W)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .step (busy),
    .opa  (in_a),
    .opb  (in_b),
    .acc  (acc)
  );

  clmul_pick #(.W(W)) u_pick (
    .mode (mode_q),
    .acc  (acc),
    .res  (res_data)
  );
endmodule

// File: rtl/clmul_iter_chk.sv
module clmul_iter_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         busy,
  input logic         res_valid,
  input logic [W-1:0] res_data
);
  localparam int KW = $clog2(W + 1) + 1;

  logic [KW-1:0] since_go;

  always_ff @(posedge clk) begin
    if (rst)                        since_go <= '0;
    else if (in_valid && in_ready)  since_go <= '0;
    else if (busy)                  since_go <= since_go + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && !res_valid && res_data == '0)); // R1

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> busy); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R3

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (since_go == KW'(W))); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !busy); // R3

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(in_valid && in_ready)) |=> $stable(res_data)); // R8
endmodule

bind clmul_iter clmul_iter_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .busy      (busy),
  .res_valid (res_valid),
  .res_data  (res_data)
);

// File: tb/clmul_iter_test.sv
module clmul_iter_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic [1:0]   in_mode = 2'b00;
  logic         busy;
  logic         res_valid;
  logic [W-1:0] res_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  clmul_iter #(.W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_mode(in_mode), .busy(busy),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p = '0;
    for (int i = 0; i < 32; i++)
      if (b[i]) p = p ^ ({32'b0, a} << i);
    return p;
  endfunction

  function automatic logic [31:0] ref_pick(input logic [63:0] p, input logic [1:0] m);
    case (m)
      2'b01:   return p[63:32];
      2'b10:   return p[62:31];
      default: return p[31:0];
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  bit          m_busy = 1'b0;
  bit          m_done = 1'b0;
  int          m_cnt  = 0;
  logic [31:0] m_a = '0, m_b = '0;
  logic [1:0]  m_mode = 2'b00;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_cnt = 0;
      m_a = '0; m_b = '0; m_mode = 2'b00;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 1'b0;
          m_done = 1'b1;
        end
      end else if (in_valid) begin
        m_busy = 1'b1; m_cnt = W;
        m_a = in_a; m_b = in_b; m_mode = in_mode;
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [31:0] e;
      chk(in_ready === !m_busy, "R2 in_ready", {63'b0, in_ready}, {63'b0, !m_busy});
      chk(busy === m_busy, "R3 busy", {63'b0, busy}, {63'b0, m_busy});
      chk(res_valid === m_done, "R3 res_valid", {63'b0, res_valid}, {63'b0, m_done});
      if (!m_busy) begin
        e = ref_pick(ref_prod(m_a, m_b), m_mode);
        case (m_mode)
          2'b01:   chk(res_data === e, "R6 R8 high result", {32'b0, res_data}, {32'b0, e});
          2'b10:   chk(res_data === e, "R7 R8 reversed result", {32'b0, res_data}, {32'b0, e});
          default: chk(res_data === e, "R4 R5 R8 low result", {32'b0, res_data}, {32'b0, e});
        endcase
      end
    end
  end

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                        output logic [31:0] r);
    bit got = 1'b0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_mode = m;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < W + 4 && !got; i++) begin
      if (res_valid) got = 1'b1;
      else @(negedge clk);
    end
    r = res_data;
    chk(got, "R3 completion seen", {63'b0, got}, 64'd1);
  endtask

  initial begin
    logic [31:0] r, r2, lo, hi, rv;
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy === 1'b0 && res_valid === 1'b0 && in_ready === 1'b1, "R1 reset flags",
        {61'b0, busy, res_valid, in_ready}, 64'd1);
    chk(res_data === '0, "R1 reset result", {32'b0, res_data}, 64'd0);

    // zeros and all-ones in each mode
    for (int m = 0; m < 4; m++) begin
      run_op('0, '0, 2'(m), r);
      chk(r === '0, "R4 zero operands", {32'b0, r}, 64'd0);
      run_op('1, '1, 2'(m), r);
      chk(r === ref_pick(ref_prod('1, '1), 2'(m)), "R4 all-ones operands",
          {32'b0, r}, {32'b0, ref_pick(ref_prod('1, '1), 2'(m))});
    end

    // random operands in random modes
    for (int k = 0; k < 200; k++) begin
      a = $urandom; b = $urandom;
      run_op(a, b, 2'($urandom), r);
    end

    // mode relations on random operands
    for (int k = 0; k < 20; k++) begin
      a = $urandom; b = $urandom;
      run_op(a, b, 2'b00, lo);
      run_op(a, b, 2'b01, hi);
      run_op(a, b, 2'b10, rv);
      chk(rv === {hi[30:0], lo[31]}, "R7 reversed vs high/low", {32'b0, rv}, {32'b0, hi[30:0], lo[31]});
      run_op(a, b ^ 32'h1, 2'b01, r2);
      chk(r2 === hi, "R6 bit0 of B ignored in high", {32'b0, r2}, {32'b0, hi});
      run_op(a, b, 2'b11, r);
      chk(r === lo, "R5 code 11 equals low", {32'b0, r}, {32'b0, lo});
    end

    // request while busy is ignored
    a = 32'h8000_0001; b = 32'hC000_0003;
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_mode = 2'b00;
    @(negedge clk);
    in_a = 32'hFFFF_0000; in_b = 32'h1234_5678; in_mode = 2'b01;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    chk(res_data === ref_prod(a, b)[31:0], "R2 busy request ignored",
        {32'b0, res_data}, {32'b0, ref_prod(a, b)[31:0]});

    // hold after completion
    r = res_data;
    repeat (10) @(negedge clk);
    chk(res_data === r, "R8 result held while idle", {32'b0, res_data}, {32'b0, r});

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired (R3 completion) actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule